// File: doc/BRIEF.md
# Predicated SIMD Immediate Right Shifter

This datapath unit applies a logical right shift by an immediate to every active lane of a packed vector. It writes the results back over the lanes of the same vector, so there is one vector input and one vector output of equal width. One combined field carries both the lane size and the shift count: a 4-bit size code and a 3-bit sub-immediate. The unit decodes a lane width of 8, 16, 32 or 64 bits from the size code. It then derives the shift count from the 7-bit concatenation of the two fields.

A per-byte predicate mask selects which lanes are shifted. A lane whose governing predicate bit is clear passes through unchanged. A size code of zero is a reserved encoding. For it the unit raises an undefined-encoding flag and returns the vector untouched.

Operands are captured on a valid strobe. The result, the undefined flag and an output valid appear one clock later. The vector length is a parameter, 256 bits by default, with one predicate bit per byte.

Top module: `vec_imm_shr`

## Requirements
- R1: `valid_o` is high exactly in the cycle after a cycle in which `valid_i` was high (one-cycle latency).
- R2: Lane width decodes from `size_i` as follows: 4'b0001 gives 8 bits, 4'b001x gives 16, 4'b01xx gives 32 and 4'b1xxx gives 64.
- R3: The shift count equals 2*lane_width minus the unsigned value of {size_i, imm_i}, where size_i forms bits [6:3] and imm_i forms bits [2:0].
- R4: Vacated high bits of each shifted lane are zero, and a shift count equal to the lane width yields a zero lane.
- R5: A lane whose governing predicate bit is 0 keeps its input value in `res_o`.
- R6: The governing bit of lane e is `pred_i[e*(lane_width/8)]`; the other predicate bits covering that lane have no effect.
- R7: When `size_i` is 4'b0000, `undef_o` is 1 and `res_o` equals `vec_i`; for any other size code, `undef_o` is 0.
- R8: In cycles without `valid_i`, `res_o` and `undef_o` hold their previous values.
- R9: After reset, `valid_o`, `undef_o` and `res_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand capture strobe |
| vec_i | input | VLEN | Source vector |
| pred_i | input | VLEN/8 | Predicate mask, one bit per byte |
| size_i | input | 4 | Size code, high part of the immediate field |
| imm_i | input | 3 | Low 3 bits of the immediate field |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| res_o | output | VLEN | Merged shifted vector |
| undef_o | output | 1 | Reserved size code seen |

## Verification
The main function is tried at each lane width with the smallest shift (1), the largest shift (the full lane width) and a mid-range count. The smallest and largest shifts separate an off-by-one in the count formula from a missing zero fill. Predicates that are all ones, sparse or mixed tell a correct merge apart from one that ignores the mask or picks the wrong lane. A pattern that sets only the non-governing predicate bits of 16-bit lanes singles out the choice of governing bit. A reserved code, plus idle cycles with changing inputs, cover the pass-through and the hold behaviour.

// File: rtl/vshr_pkg.sv
package vshr_pkg;
  localparam int unsigned SIZE_W  = 4;
  localparam int unsigned IMM_W   = 3;
  localparam int unsigned FIELD_W = SIZE_W + IMM_W;
  localparam int unsigned SHAMT_W = FIELD_W + 1;

  typedef enum logic [1:0] {
    LANE_B = 2'd0,
    LANE_H = 2'd1,
    LANE_S = 2'd2,
    LANE_D = 2'd3
  } lane_e;

  typedef struct packed {
    lane_e              lane;
    logic [SHAMT_W-1:0] shamt;
    logic               undef;
  } dec_t;

  function automatic int unsigned lane_bits(lane_e l);
    return 8 << l;
  endfunction
endpackage

// File: rtl/vshr_decode.sv
module vshr_decode
  import vshr_pkg::*;
(
  input  logic [SIZE_W-1:0] size_i,
  input  logic [IMM_W-1:0]  imm_i,
  output dec_t              dec_o
);
  logic [SHAMT_W-1:0] field;
  logic [SHAMT_W-1:0] twice_w;

  assign field = {1'b0, size_i, imm_i};

  always_comb begin
    dec_o.undef = 1'b0;
    dec_o.lane  = LANE_B;
    casez (size_i)
      4'b0000: dec_o.undef = 1'b1;
      4'b0001: dec_o.lane  = LANE_B;
      4'b001?: dec_o.lane  = LANE_H;
      4'b01??: dec_o.lane  = LANE_S;
      default: dec_o.lane  = LANE_D;
    endcase
  end

  assign twice_w     = SHAMT_W'(2 * lane_bits(dec_o.lane));
  assign dec_o.shamt = dec_o.undef ? '0 : (twice_w - field);
endmodule

// File: rtl/vshr_lanes.sv
module vshr_lanes
  import vshr_pkg::*;
#(
  parameter int unsigned VLEN   = 256,
  parameter int unsigned LANE_W = 8
) (
  input  logic [VLEN-1:0]   vec_i,
  input  logic [VLEN/8-1:0] pred_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  output logic [VLEN-1:0]   res_o
);
  localparam int unsigned NLANE = VLEN / LANE_W;
  localparam int unsigned PSTEP = LANE_W / 8;

  logic unused_pred;
  assign unused_pred = ^pred_i;

  for (genvar e = 0; e < NLANE; e++) begin : g_lane
    logic [LANE_W-1:0] src;
    logic [LANE_W-1:0] shd;
    assign src = vec_i[e*LANE_W +: LANE_W];
    // count may equal LANE_W; the wide compare forces an all-zero lane
    assign shd = (shamt_i >= SHAMT_W'(LANE_W)) ? '0 : (src >> shamt_i);
    assign res_o[e*LANE_W +: LANE_W] = pred_i[e*PSTEP] ? shd : src;
  end
endmodule

// File: rtl/vec_imm_shr.sv
module vec_imm_shr
  import vshr_pkg::*;
#(
  parameter int unsigned VLEN = 256
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [VLEN-1:0]     vec_i,
  input  logic [VLEN/8-1:0]   pred_i,
  input  logic [SIZE_W-1:0]   size_i,
  input  logic [IMM_W-1:0]    imm_i,
  output logic                valid_o,
  output logic [VLEN-1:0]     res_o,
  output logic                undef_o
);
  localparam int unsigned PRED_W = VLEN / 8;
  localparam int unsigned NSIZE  = 4;

  dec_t            dec;
  logic [VLEN-1:0] by_size [NSIZE];
  logic [VLEN-1:0] res_d;

  vshr_decode u_dec (
    .size_i (size_i),
    .imm_i  (imm_i),
    .dec_o  (dec)
  );

  for (genvar s = 0; s < NSIZE; s++) begin : g_size
    vshr_lanes #(
      .VLEN   (VLEN),
      .LANE_W (8 << s)
    ) u_lanes (
      .vec_i   (vec_i),
      .pred_i  (pred_i),
      .shamt_i (dec.shamt),
      .res_o   (by_size[s])
    );
  end

  always_comb begin
    if (dec.undef) res_d = vec_i;
    else           res_d = by_size[dec.lane];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
      undef_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o   <= res_d;
        undef_o <= dec.undef;
      end
    end
  end

  p_valid_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_valid_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_shamt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !dec.undef) |->
      (dec.shamt >= SHAMT_W'(1) && dec.shamt <= SHAMT_W'(lane_bits(dec.lane))));
  p_undef_pass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == '0) |=> (undef_o && res_o == $past(vec_i)));
  p_def_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i != '0) |=> !undef_o);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(res_o) && $stable(undef_o)));

  initial begin
    assert (VLEN % 64 == 0 && PRED_W * 8 == VLEN)
      else $error("VLEN must be a multiple of 64");
  end
endmodule

// File: tb/tb_vec_imm_shr.sv
`timescale 1ns/1ps
module tb_vec_imm_shr;
  localparam int VLEN = 256;
  localparam int PW   = VLEN / 8;

  typedef struct packed {
    logic [3:0]    sz;
    logic [2:0]    imm;
    logic [PW-1:0] pred;
    logic [7:0]    seed;
  } vec_t;

  // R2/R3/R4/R5 table: size, imm, predicate, pattern seed
  localparam int NT = 11;
  localparam vec_t TBL [NT] = '{
    '{4'b0001, 3'd7, 32'hFFFF_FFFF, 8'd1},  // B shift 1
    '{4'b0001, 3'd0, 32'hFFFF_FFFF, 8'd2},  // B shift 8 -> zero
    '{4'b0001, 3'd5, 32'hA5A5_0F3C, 8'd3},  // B shift 3 mixed pred
    '{4'b0010, 3'd0, 32'h5555_5555, 8'd4},  // H shift 16 -> zero
    '{4'b0011, 3'd3, 32'h1144_0511, 8'd5},  // H shift 5
    '{4'b0100, 3'd0, 32'h1111_1111, 8'd6},  // S shift 32 -> zero
    '{4'b0110, 3'd3, 32'h0F0F_1111, 8'd7},  // S shift 13
    '{4'b1000, 3'd0, 32'h0101_0101, 8'd8},  // D shift 64 -> zero
    '{4'b1111, 3'd7, 32'hFFFF_FFFF, 8'd9},  // D shift 1
    '{4'b1011, 3'd3, 32'h0100_0001, 8'd10}, // D shift 37 sparse
    '{4'b0000, 3'd4, 32'hFFFF_FFFF, 8'd11}  // reserved
  };

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            valid_i = 1'b0;
  logic [VLEN-1:0] vec_i = '0;
  logic [PW-1:0]   pred_i = '0;
  logic [3:0]      size_i = '0;
  logic [2:0]      imm_i = '0;
  logic            valid_o;
  logic [VLEN-1:0] res_o;
  logic            undef_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vec_imm_shr #(.VLEN(VLEN)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .vec_i(vec_i),
    .pred_i(pred_i), .size_i(size_i), .imm_i(imm_i),
    .valid_o(valid_o), .res_o(res_o), .undef_o(undef_o)
  );

  function automatic logic [VLEN-1:0] gen_vec(logic [7:0] seed);
    logic [VLEN-1:0] v;
    for (int i = 0; i < VLEN / 32; i++)
      v[i*32 +: 32] = (32'h9E37_79B9 * (32'(seed) + 32'(i) + 1)) ^ {seed, 24'hA5_C3F1};
    return v;
  endfunction

  function automatic logic [VLEN-1:0] model(logic [VLEN-1:0] v, logic [PW-1:0] p,
                                            logic [3:0] sz, logic [2:0] im,
                                            output logic und);
    int esz, sh;
    logic [VLEN-1:0] msk, lane, r;
    und = 1'b0;
    casez (sz)
      4'b0000: esz = 0;
      4'b0001: esz = 8;
      4'b001?: esz = 16;
      4'b01??: esz = 32;
      default: esz = 64;
    endcase
    if (esz == 0) begin
      und = 1'b1;
      return v;
    end
    sh  = 2 * esz - int'({sz, im});
    msk = (VLEN'(1) << esz) - VLEN'(1);
    r   = '0;
    for (int e = 0; e < VLEN / esz; e++) begin
      lane = (v >> (e * esz)) & msk;
      if (p[e * esz / 8]) lane = lane >> sh;
      r = r | (lane << (e * esz));
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [VLEN-1:0] v, logic [PW-1:0] p, logic [3:0] sz, logic [2:0] im);
    @(negedge clk);
    vec_i = v; pred_i = p; size_i = sz; imm_i = im; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  initial begin
    logic [VLEN-1:0] exp, v, held;
    logic            eu;

    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 valid_o", VLEN'(valid_o), '0);
    chk("R9 res_o", res_o, '0);
    chk("R9 undef_o", VLEN'(undef_o), '0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int t = 0; t < NT; t++) begin
      v   = gen_vec(TBL[t].seed);
      exp = model(v, TBL[t].pred, TBL[t].sz, TBL[t].imm, eu);
      apply(v, TBL[t].pred, TBL[t].sz, TBL[t].imm);
      chk($sformatf("R3/R4/R5 row %0d res", t), res_o, exp);
      chk($sformatf("R7 row %0d undef", t), VLEN'(undef_o), VLEN'(eu));
      chk($sformatf("R1 row %0d valid", t), VLEN'(valid_o), VLEN'(1));
    end

    // R1 valid drops with no strobe
    @(negedge clk);
    chk("R1 idle valid", VLEN'(valid_o), '0);

    // R4 all-ones B lanes shifted by 8 give zero, by 1 give 7F
    apply({VLEN{1'b1}}, '1, 4'b0001, 3'd0);
    chk("R4 full shift zero", res_o, '0);
    apply({VLEN{1'b1}}, '1, 4'b0001, 3'd7);
    chk("R4 zero fill", res_o, {(VLEN/8){8'h7F}});

    // R2 distinct widths on one pattern: same count 4, different lanes
    v = {(VLEN/64){64'h8000_0000_0000_0000}} | {(VLEN/8){8'h80}};
    apply(v, '1, 4'b0001, 3'd4);
    chk("R2 lane 8", res_o, model(v, '1, 4'b0001, 3'd4, eu));
    apply(v, '1, 4'b0011, 3'd4);
    chk("R2 lane 16", res_o, model(v, '1, 4'b0011, 3'd4, eu));
    apply(v, '1, 4'b0111, 3'd4);
    chk("R2 lane 32", res_o, model(v, '1, 4'b0111, 3'd4, eu));
    apply(v, '1, 4'b1111, 3'd4);
    chk("R2 lane 64", res_o, model(v, '1, 4'b1111, 3'd4, eu));

    // R6 only odd predicate bits set for 16-bit lanes: nothing shifts
    v = gen_vec(8'd77);
    apply(v, 32'hAAAA_AAAA, 4'b0011, 3'd7);
    chk("R6 upper pred bits ignored", res_o, v);
    // R5 all-zero predicate leaves vector unchanged
    apply(v, '0, 4'b1001, 3'd1);
    chk("R5 inactive lanes kept", res_o, v);

    // R8 hold while idle with changing inputs
    apply(gen_vec(8'd5), '1, 4'b0001, 3'd7);
    held = res_o;
    @(negedge clk);
    vec_i = gen_vec(8'd99); size_i = 4'b0000; pred_i = '0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 res held", res_o, held);
    chk("R8 undef held", VLEN'(undef_o), '0);

    // R7 reserved code passes vector through
    v = gen_vec(8'd42);
    apply(v, '1, 4'b0000, 3'd0);
    chk("R7 passthrough", res_o, v);
    chk("R7 flag", VLEN'(undef_o), VLEN'(1));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule